// File: doc/BRIEF.md
# Selectable-Operand Arithmetic Circuit

A combinational arithmetic unit that derives seven operations from a single ripple-carry adder. The adder always forms D = A + Y + Cin; what changes between operations is the second operand Y, which a per-bit four-way selector takes from B, the bitwise inverse of B, an all-zero word or an all-one word. Pairing each of those four choices with the carry-in gives add, add with carry, subtract, subtract with borrow, increment, decrement and transfer. The transfer is reachable two ways, which is why eight select combinations give only seven distinct results.

The unit sits inside a datapath where a controller drives the two select bits and the carry-in together with the operands. Its outputs follow its inputs with no clock. The adder exposes the carry out of the top bit and a signed overflow flag. The overflow flag is formed from the carries into and out of the top bit.

Top module: `arith_sel_unit`

## Requirements
- R1: With sel_i = 2'b00 the operand is B: d_o is the low WIDTH bits of A + B + cin_i and cout_o is bit WIDTH of that sum.
- R2: With sel_i = 2'b01 and cin_i = 1 the result is A - B in two's complement. cout_o is 1 exactly when A >= B unsigned. For A < B, d_o is the two's complement of B - A (for example, 3 - 5 at 4 bits gives 4'b1110).
- R3: With sel_i = 2'b01 and cin_i = 0 the result is A + ~B, that is A - B - 1, with cout_o the carry of that sum.
- R4: With sel_i = 2'b10 and cin_i = 0, d_o equals A and cout_o is 0.
- R5: With sel_i = 2'b10 and cin_i = 1, d_o is A + 1. cout_o is 1 only when A is all ones.
- R6: With sel_i = 2'b11 and cin_i = 0, d_o is A - 1 (A plus an all-ones word). cout_o is 0 only when A is zero.
- R7: With sel_i = 2'b11 and cin_i = 1, d_o equals A and cout_o is 1.
- R8: ovf_o is the XOR of the carry into the top bit and the carry out of it. This equals 1 exactly when A and the selected operand share a sign bit and d_o's sign bit differs from it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First adder operand |
| b_i | input | WIDTH | Source for the selected second operand |
| sel_i | input | 2 | Operand select: 00 B, 01 ~B, 10 zero, 11 all ones |
| cin_i | input | 1 | Carry into bit 0 |
| d_o | output | WIDTH | Sum A + Y + Cin |
| cout_o | output | 1 | Carry out of the top bit |
| ovf_o | output | 1 | Signed overflow flag |

## Verification
The hardest outputs to reach are the overflow flag in the increment, decrement and subtract modes. Here the second operand is not B, so the flag depends on a sign that is never driven at the ports. Examples are 0111 incremented and 1000 decremented or reduced by one. Directed vectors aim at those edges: the all-ones wrap of the increment and the zero wrap of the decrement. A sweep over every select, carry and operand pair at the default width then compares each result with a behavioural model of the operand choice and sum.

// File: rtl/arith_sel_pkg.sv
package arith_sel_pkg;
  typedef enum logic [1:0] {
    OPND_B    = 2'b00,
    OPND_NB   = 2'b01,
    OPND_ZERO = 2'b10,
    OPND_ONES = 2'b11
  } opnd_sel_e;
endpackage

// File: rtl/opnd_mux.sv
module opnd_mux
  import arith_sel_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] b_i,
  input  opnd_sel_e        sel_i,
  output logic [WIDTH-1:0] y_o
);
  // one four-way selector per bit
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_comb begin
      unique case (sel_i)
        OPND_B:    y_o[i] = b_i[i];
        OPND_NB:   y_o[i] = ~b_i[i];
        OPND_ZERO: y_o[i] = 1'b0;
        default:   y_o[i] = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/fa_cell.sv
module fa_cell (
  input  logic x_i,
  input  logic y_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);
  logic p;
  assign p   = x_i ^ y_i;
  assign s_o = p ^ c_i;
  assign c_o = (x_i & y_i) | (p & c_i);
endmodule

// File: rtl/ripple_add.sv
module ripple_add #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] s_o,
  output logic             c_top_in_o,
  output logic             cout_o
);
  logic [WIDTH:0] c;
  assign c[0] = cin_i;

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    fa_cell u_fa (
      .x_i (x_i[i]),
      .y_i (y_i[i]),
      .c_i (c[i]),
      .s_o (s_o[i]),
      .c_o (c[i+1])
    );
  end

  assign c_top_in_o = c[WIDTH-1];
  assign cout_o     = c[WIDTH];
endmodule

// File: rtl/arith_sel_unit.sv
module arith_sel_unit
  import arith_sel_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [1:0]       sel_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] d_o,
  output logic             cout_o,
  output logic             ovf_o
);
  localparam int MSB = WIDTH - 1;

  opnd_sel_e        sel;
  logic [WIDTH-1:0] y;
  logic             c_top_in;

  assign sel = opnd_sel_e'(sel_i);

  opnd_mux #(.WIDTH(WIDTH)) u_mux (
    .b_i   (b_i),
    .sel_i (sel),
    .y_o   (y)
  );

  ripple_add #(.WIDTH(WIDTH)) u_add (
    .x_i        (a_i),
    .y_i        (y),
    .cin_i      (cin_i),
    .s_o        (d_o),
    .c_top_in_o (c_top_in),
    .cout_o     (cout_o)
  );

  // R8
  assign ovf_o = c_top_in ^ cout_o;

  logic [WIDTH:0] ref_sum;
  always_comb begin
    ref_sum = {1'b0, a_i} + {1'b0, y} + {{WIDTH{1'b0}}, cin_i};
    // R1
    sum_chk: assert ({cout_o, d_o} == ref_sum);
    // R8
    ovf_sign_chk: assert (ovf_o == ((a_i[MSB] == y[MSB]) && (d_o[MSB] != a_i[MSB])));
    // R2
    if (sel == OPND_NB && cin_i) begin
      sub_chk: assert (d_o == a_i - b_i && cout_o == (a_i >= b_i));
    end
    // R4
    if (sel == OPND_ZERO && !cin_i) begin
      xfer_chk: assert (d_o == a_i && !cout_o);
    end
    // R6
    if (sel == OPND_ONES && !cin_i) begin
      dec_chk: assert (d_o == a_i - 1'b1 && cout_o == (a_i != '0));
    end
    // R7
    if (sel == OPND_ONES && cin_i) begin
      xfer_ones_chk: assert (d_o == a_i && cout_o);
    end
  end
endmodule

// File: tb/sim_arith_sel_unit.sv
module sim_arith_sel_unit;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] a, b, d;
  logic [1:0]   sel;
  logic         cin, cout, ovf;
  int           n_vec = 0;
  int           n_bad = 0;

  always #4 clk = ~clk;  // 125 MHz

  arith_sel_unit #(.WIDTH(W)) u0 (
    .a_i    (a),
    .b_i    (b),
    .sel_i  (sel),
    .cin_i  (cin),
    .d_o    (d),
    .cout_o (cout),
    .ovf_o  (ovf)
  );

  // {sel, cin, a, b, exp_d, exp_cout, exp_ovf}
  localparam int NV = 14;
  localparam logic [16:0] VEC [NV] = '{
    {2'b00, 1'b0, 4'h3, 4'h5, 4'h8, 1'b0, 1'b1},  // R1 R8
    {2'b00, 1'b1, 4'h9, 4'h7, 4'h1, 1'b1, 1'b0},  // R1
    {2'b00, 1'b0, 4'hF, 4'hF, 4'hE, 1'b1, 1'b0},  // R1
    {2'b01, 1'b1, 4'h3, 4'h5, 4'hE, 1'b0, 1'b0},  // R2 3-5
    {2'b01, 1'b1, 4'h7, 4'h2, 4'h5, 1'b1, 1'b0},  // R2
    {2'b01, 1'b1, 4'h8, 4'h1, 4'h7, 1'b1, 1'b1},  // R2 R8
    {2'b01, 1'b0, 4'h6, 4'h2, 4'h3, 1'b1, 1'b0},  // R3
    {2'b10, 1'b0, 4'hB, 4'hF, 4'hB, 1'b0, 1'b0},  // R4
    {2'b10, 1'b1, 4'hF, 4'h0, 4'h0, 1'b1, 1'b0},  // R5
    {2'b10, 1'b1, 4'h7, 4'h3, 4'h8, 1'b0, 1'b1},  // R5 R8
    {2'b11, 1'b0, 4'h0, 4'h5, 4'hF, 1'b0, 1'b0},  // R6
    {2'b11, 1'b0, 4'h8, 4'h0, 4'h7, 1'b1, 1'b1},  // R6 R8
    {2'b11, 1'b1, 4'h6, 4'h9, 4'h6, 1'b1, 1'b0},  // R7
    {2'b11, 1'b1, 4'hF, 4'h0, 4'hF, 1'b1, 1'b0}   // R7
  };

  function automatic string req_of(logic [1:0] s, logic c);
    case ({s, c})
      3'b000, 3'b001: return "R1";
      3'b011:         return "R2";
      3'b010:         return "R3";
      3'b100:         return "R4";
      3'b101:         return "R5";
      3'b110:         return "R6";
      default:        return "R7";
    endcase
  endfunction

  task automatic apply(input logic [1:0] s, input logic c,
                       input logic [W-1:0] av, input logic [W-1:0] bv);
    @(negedge clk);
    sel = s; cin = c; a = av; b = bv;
    #1;
  endtask

  task automatic check(input string req, input logic [W-1:0] ed,
                       input logic ec, input logic ev);
    n_vec++;
    if (d !== ed || cout !== ec) begin
      n_bad++;
      $display("FAIL %s sel=%b cin=%b a=%h b=%h: d=%h cout=%b, expected d=%h cout=%b",
               req, sel, cin, a, b, d, cout, ed, ec);
    end
    if (ovf !== ev) begin
      n_bad++;
      $display("FAIL R8 sel=%b cin=%b a=%h b=%h: ovf=%b, expected %b",
               sel, cin, a, b, ovf, ev);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    sel = 2'b00; cin = 1'b0; a = '0; b = '0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    // reset state: zero inputs give zero outputs (R1)
    apply(2'b00, 1'b0, '0, '0);
    check("R1", '0, 1'b0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][16:15], VEC[i][14], VEC[i][13:10], VEC[i][9:6]);
      check(req_of(VEC[i][16:15], VEC[i][14]), VEC[i][5:2], VEC[i][1], VEC[i][0]);
    end

    // sweep against a behavioural model of operand choice and sum
    for (int s = 0; s < 4; s++) begin
      for (int c = 0; c < 2; c++) begin
        for (int av = 0; av < (1 << W); av++) begin
          for (int bv = 0; bv < (1 << W); bv++) begin
            logic [W-1:0] yv;
            logic [W:0]   sum;
            logic         vv;
            case (s)
              0: yv = W'(bv);
              1: yv = ~W'(bv);
              2: yv = '0;
              default: yv = '1;
            endcase
            sum = {1'b0, W'(av)} + {1'b0, yv} + (W+1)'(c);
            vv = (av[W-1] == yv[W-1]) && (sum[W-1] != av[W-1]);
            apply(2'(s), 1'(c), W'(av), W'(bv));
            check(req_of(2'(s), 1'(c)), sum[W-1:0], sum[W], vv);
          end
        end
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule